// File: doc/BRIEF.md
# Two-Port Word Memory with Same-Address Arbitration

This block is a synchronous two-port memory. Two ports, left and right, each carry their own select, write strobe, output enable, semaphore-space select, word address and byte-wide data path, and either port may read or write any word in any cycle independently of the other. Each port's controls are decoded every cycle into one of five modes: powered down, semaphore space, write, read, or read with outputs switched off. A tri-state data bus is modelled as a data output together with a drive flag. While the flag is low, the data output is forced to zero.

When both ports touch the same word in the same cycle, an arbiter chooses a winner and raises a busy flag towards the loser. A write from a busy port is dropped. A master/slave select picks where busy comes from. In master mode, the arbiter produces busy and drives it on the busy outputs. In slave mode, the busy outputs stay low and each port's busy is taken from its busy input. This lets a master device gate the writes of a slave device that sits beside it on a wider data word.

The depth is 2^ADDR_W words (default ADDR_W = 10). Setting ADDR_W = 13 gives 8192 words. The width is DATA_W bits (default 8).

Top module: `dpram_arb`

## Requirements
- R1: While reset is asserted and right after it is released, both drive flags and both busy outputs are low, and both data outputs are zero.
- R2: A port whose select is high (power-down) writes nothing. Its drive flag is low and its data output is zero in the following cycle.
- R3: A port with select low, write strobe low and semaphore select high, and whose busy is low, stores its input word at its address at the clock edge.
- R4: A port with select low, write strobe high, output enable low and semaphore select high reads. In the next cycle its drive flag is high and its data output holds the word stored before that edge, so a write in the same cycle is not yet visible.
- R5: When output enable is high, the port's drive flag is low in the next cycle. A write (write strobe low) is still performed.
- R6: A port with select low and semaphore select low does not access the array. It neither writes nor drives.
- R7: When the two ports use different addresses, neither is busy, and simultaneous writes from both ports are both stored.
- R8: In master mode, when both ports are accessing (select low, semaphore select high) the same address in the same cycle, exactly one busy output is high in that same cycle. On a fresh tie, the left port wins and the right busy output is raised.
- R9: If one port was already accessing an address in the previous cycle and the other port was not, that earlier port wins when the other port arrives at the same address. While contention lasts from one cycle to the next, the winner is kept.
- R10: The write of a busy port is suppressed. After a same-address write conflict, exactly the winner's word is stored.
- R11: In slave mode, both busy outputs are low and each port's busy comes from its busy input. A busy input suppresses that port's write. With no busy input, simultaneous same-address writes leave the left port's word stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_sel | input | 1 | 1 = master (arbiter drives busy), 0 = slave (busy taken in) |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left semaphore-space select, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left busy from an external master (slave mode) |
| l_rdata | output | DATA_W | Left read data, zero when not driving |
| l_drive | output | 1 | Left data-drive flag |
| l_busy_o | output | 1 | Left busy from the arbiter (master mode) |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right semaphore-space select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right busy from an external master (slave mode) |
| r_rdata | output | DATA_W | Right read data, zero when not driving |
| r_drive | output | 1 | Right data-drive flag |
| r_busy_o | output | 1 | Right busy from the arbiter (master mode) |

## Verification
The two functions that can fall in the same cycle are the two ports' accesses to one word: a write against a write, or a write against a read. The bench provokes these with directed fresh ties, late arrivals at an address that the other port already holds, and a random phase that confines both ports to eight addresses so that collisions are frequent. In each collision the busy outputs are sampled in the cycle itself. The stored word is read back later and compared with a bench model that applies only the winner's write and serves reads with the data held before the edge.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [2:0] {
    PM_OFF,
    PM_SEM,
    PM_WRITE,
    PM_READ,
    PM_HIZ
  } port_mode_e;

  typedef enum logic {
    WIN_LEFT,
    WIN_RIGHT
  } winner_e;

  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/port_decode.sv
module port_decode
  import dpa_pkg::*;
(
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic sem_n,
  output logic access,
  output logic wr_req,
  output logic rd_req
);
  port_mode_e mode;

  always_comb begin
    if (cs_n)       mode = PM_OFF;
    else if (!sem_n) mode = PM_SEM;
    else if (!we_n)  mode = PM_WRITE;
    else if (!oe_n)  mode = PM_READ;
    else             mode = PM_HIZ;
  end

  assign access = (mode == PM_WRITE) || (mode == PM_READ) || (mode == PM_HIZ);
  assign wr_req = (mode == PM_WRITE);
  assign rd_req = (mode == PM_READ);
endmodule

// File: rtl/contention_arb.sv
module contention_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_act,
  input  logic              r_act,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              busy_l,
  output logic              busy_r
);
  logic              prev_l_act_q, prev_r_act_q;
  logic [ADDR_W-1:0] prev_l_addr_q, prev_r_addr_q;
  logic              match_q;
  winner_e           win_q, win_d;
  logic              match, l_held, r_held;

  assign match  = l_act && r_act && (l_addr == r_addr);
  assign l_held = prev_l_act_q && (prev_l_addr_q == l_addr);
  assign r_held = prev_r_act_q && (prev_r_addr_q == r_addr);

  always_comb begin
    win_d = WIN_LEFT;
    if (match) begin
      if (match_q)              win_d = win_q;
      else if (r_held && !l_held) win_d = WIN_RIGHT;
      else                      win_d = WIN_LEFT;
    end
  end

  assign busy_l = match && (win_d == WIN_RIGHT);
  assign busy_r = match && (win_d == WIN_LEFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l_act_q  <= 1'b0;
      prev_r_act_q  <= 1'b0;
      prev_l_addr_q <= '0;
      prev_r_addr_q <= '0;
      match_q       <= 1'b0;
      win_q         <= WIN_LEFT;
    end else begin
      prev_l_act_q  <= l_act;
      prev_r_act_q  <= r_act;
      prev_l_addr_q <= l_addr;
      prev_r_addr_q <= r_addr;
      match_q       <= match;
      win_q         <= win_d;
    end
  end
endmodule

// File: rtl/dp_storage.sv
module dp_storage #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              l_we,
  input  logic              l_re,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_we,
  input  logic              r_re,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right applied first so the left word survives an ungated collision.
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (l_we) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk) begin
    if (l_re) l_rdata <= mem[l_addr];
    if (r_re) r_rdata <= mem[r_addr];
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_sel,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic              l_sem_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_i,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_drive,
  output logic              l_busy_o,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic              r_sem_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_i,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_drive,
  output logic              r_busy_o
);
  logic rst_m, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic cs_n_v  [NUM_PORTS];
  logic we_n_v  [NUM_PORTS];
  logic oe_n_v  [NUM_PORTS];
  logic sem_n_v [NUM_PORTS];
  logic busy_i_v[NUM_PORTS];
  logic arb_busy[NUM_PORTS];
  logic access  [NUM_PORTS];
  logic wr_req  [NUM_PORTS];
  logic rd_req  [NUM_PORTS];
  logic eff_busy[NUM_PORTS];
  logic wr_en   [NUM_PORTS];
  logic drive_q [NUM_PORTS];

  assign cs_n_v[0]   = l_cs_n;   assign cs_n_v[1]   = r_cs_n;
  assign we_n_v[0]   = l_we_n;   assign we_n_v[1]   = r_we_n;
  assign oe_n_v[0]   = l_oe_n;   assign oe_n_v[1]   = r_oe_n;
  assign sem_n_v[0]  = l_sem_n;  assign sem_n_v[1]  = r_sem_n;
  assign busy_i_v[0] = l_busy_i; assign busy_i_v[1] = r_busy_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_decode u_dec (
      .cs_n  (cs_n_v[p]),
      .we_n  (we_n_v[p]),
      .oe_n  (oe_n_v[p]),
      .sem_n (sem_n_v[p]),
      .access(access[p]),
      .wr_req(wr_req[p]),
      .rd_req(rd_req[p])
    );

    assign eff_busy[p] = ms_sel ? arb_busy[p] : busy_i_v[p];
    assign wr_en[p]    = wr_req[p] && !eff_busy[p];

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) drive_q[p] <= 1'b0;
      else        drive_q[p] <= rd_req[p];
    end
  end

  contention_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_q),
    .l_act (access[0]),
    .r_act (access[1]),
    .l_addr(l_addr),
    .r_addr(r_addr),
    .busy_l(arb_busy[0]),
    .busy_r(arb_busy[1])
  );

  logic [DATA_W-1:0] l_mem_q, r_mem_q;

  dp_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .l_we   (wr_en[0]),
    .l_re   (rd_req[0]),
    .l_addr (l_addr),
    .l_wdata(l_wdata),
    .l_rdata(l_mem_q),
    .r_we   (wr_en[1]),
    .r_re   (rd_req[1]),
    .r_addr (r_addr),
    .r_wdata(r_wdata),
    .r_rdata(r_mem_q)
  );

  assign l_drive  = drive_q[0];
  assign r_drive  = drive_q[1];
  assign l_rdata  = drive_q[0] ? l_mem_q : '0;
  assign r_rdata  = drive_q[1] ? r_mem_q : '0;
  assign l_busy_o = ms_sel && arb_busy[0];
  assign r_busy_o = ms_sel && arb_busy[1];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_sel,
  input logic              l_cs_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic              l_sem_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_cs_n,
  input logic              r_sem_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_drive,
  input logic              r_drive,
  input logic              l_busy_o,
  input logic              r_busy_o
);
  logic both_same;
  assign both_same = !l_cs_n && l_sem_n && !r_cs_n && r_sem_n && (l_addr == r_addr);

  AST_NO_DUAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_o && r_busy_o)); // R8
  AST_CONFLICT_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && both_same) |-> (l_busy_o != r_busy_o)); // R8
  AST_DIFF_ADDR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_addr != r_addr) |-> (!l_busy_o && !r_busy_o)); // R7
  AST_SLAVE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_sel |-> (!l_busy_o && !r_busy_o)); // R11
  AST_L_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    l_cs_n |=> !l_drive); // R2
  AST_R_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    r_cs_n |=> !r_drive); // R2
  AST_L_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && l_we_n && !l_oe_n && l_sem_n) |=> l_drive); // R4
  AST_L_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    l_oe_n |=> !l_drive); // R5
  AST_L_SEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !l_sem_n |=> !l_drive); // R6
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .ms_sel  (ms_sel),
  .l_cs_n  (l_cs_n),
  .l_we_n  (l_we_n),
  .l_oe_n  (l_oe_n),
  .l_sem_n (l_sem_n),
  .l_addr  (l_addr),
  .r_cs_n  (r_cs_n),
  .r_sem_n (r_sem_n),
  .r_addr  (r_addr),
  .l_drive (l_drive),
  .r_drive (r_drive),
  .l_busy_o(l_busy_o),
  .r_busy_o(r_busy_o)
);

// File: tb/sim_dpram_arb.sv
`timescale 1ns/1ps
module sim_dpram_arb;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_sel;
  logic l_cs_n, l_we_n, l_oe_n, l_sem_n, l_busy_i;
  logic r_cs_n, r_we_n, r_oe_n, r_sem_n, r_busy_i;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_drive, r_drive, l_busy_o, r_busy_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_sem_n(l_sem_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_busy_i(l_busy_i),
    .l_rdata(l_rdata), .l_drive(l_drive), .l_busy_o(l_busy_o),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_sem_n(r_sem_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_busy_i(r_busy_i),
    .r_rdata(r_rdata), .r_drive(r_drive), .r_busy_o(r_busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_sem_n = 1; l_busy_i = 0;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_sem_n = 1; r_busy_i = 0;
  endtask

  // op: 0 off, 1 write, 2 read, 3 read with outputs off
  task automatic setp(input bit left, input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (left) begin
      l_cs_n = (op == 0); l_we_n = (op != 1); l_oe_n = (op == 3); l_sem_n = 1;
      l_addr = a; l_wdata = d;
    end else begin
      r_cs_n = (op == 0); r_we_n = (op != 1); r_oe_n = (op == 3); r_sem_n = 1;
      r_addr = a; r_wdata = d;
    end
  endtask

  task automatic rd_left(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    idle(); setp(1, 2, a, 0); step();
    chk(req, {31'd0, l_drive}, 1);
    chk(req, {24'd0, l_rdata}, {24'd0, exp});
    idle();
  endtask

  // bench model for the random phase
  logic [DW-1:0] model [8];
  bit p_la_act, p_ra_act, p_match, p_win;
  logic [AW-1:0] p_la, p_ra;

  task automatic cyc(input int lop, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input int rop, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    bit l_act, r_act, match, rheld, lheld, win, bl, br;
    logic [DW-1:0] exp_l, exp_r;
    setp(1, lop, la, ld);
    setp(0, rop, ra, rd);
    l_act = (lop != 0); r_act = (rop != 0);
    match = l_act && r_act && (la == ra);
    lheld = p_la_act && (p_la == la);
    rheld = p_ra_act && (p_ra == ra);
    win = 0;
    if (match) win = p_match ? p_win : (rheld && !lheld);
    bl = match && win;
    br = match && !win;
    #1;
    chk("R8/R9 left busy", {31'd0, l_busy_o}, {31'd0, bl});
    chk("R8/R9 right busy", {31'd0, r_busy_o}, {31'd0, br});
    exp_l = model[la[2:0]];
    exp_r = model[ra[2:0]];
    if (rop == 1 && !br) model[ra[2:0]] = rd;
    if (lop == 1 && !bl) model[la[2:0]] = ld;
    step();
    chk("R4/R5 left drive", {31'd0, l_drive}, {31'd0, (lop == 2)});
    chk("R4/R5 right drive", {31'd0, r_drive}, {31'd0, (rop == 2)});
    if (lop == 2) chk("R4/R10 left data", {24'd0, l_rdata}, {24'd0, exp_l});
    if (rop == 2) chk("R4/R10 right data", {24'd0, r_rdata}, {24'd0, exp_r});
    p_la_act = l_act; p_ra_act = r_act; p_la = la; p_ra = ra;
    p_match = match; p_win = win;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; ms_sel = 1; idle();
    l_addr = 0; r_addr = 1; l_wdata = 0; r_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 left drive in reset", {31'd0, l_drive}, 0);
    chk("R1 right drive in reset", {31'd0, r_drive}, 0);
    chk("R1 left data in reset", {24'd0, l_rdata}, 0);
    chk("R1 busy in reset", {30'd0, l_busy_o, r_busy_o}, 0);
    rst_n = 1;
    repeat (3) step();
    chk("R1 drive after release", {30'd0, l_drive, r_drive}, 0);

    // R3 R7: parallel writes to distinct words
    setp(1, 1, 10'd5, 8'hA5); setp(0, 1, 10'd9, 8'h3C);
    #1 chk("R7 no busy on distinct addr", {30'd0, l_busy_o, r_busy_o}, 0);
    step(); idle();
    setp(1, 2, 10'd9, 0); setp(0, 2, 10'd5, 0); step();
    chk("R7 left reads right's word", {24'd0, l_rdata}, 8'h3C);
    chk("R3 right reads left's word", {24'd0, r_rdata}, 8'hA5);
    chk("R4 both drive", {30'd0, l_drive, r_drive}, 2'b11);
    idle();

    // R5: outputs off on read, write still done with oe high
    setp(1, 3, 10'd5, 0); step();
    chk("R5 read with oe high no drive", {31'd0, l_drive}, 0);
    chk("R5 data zero when off", {24'd0, l_rdata}, 0);
    idle(); setp(1, 1, 10'd12, 8'h77); l_oe_n = 1; step();
    rd_left(10'd12, 8'h77, "R5 write with oe high");

    // R2: power-down ignores write
    idle(); l_cs_n = 1; l_we_n = 0; l_addr = 10'd5; l_wdata = 8'hFF; step();
    chk("R2 no drive in power-down", {31'd0, l_drive}, 0);
    rd_left(10'd5, 8'hA5, "R2 power-down write ignored");

    // R6: semaphore space does not touch array
    idle(); l_cs_n = 0; l_sem_n = 0; l_we_n = 0; l_addr = 10'd5; l_wdata = 8'hEE; step();
    chk("R6 no drive in semaphore space", {31'd0, l_drive}, 0);
    l_cs_n = 0; l_sem_n = 0; l_we_n = 1; l_oe_n = 0; step();
    chk("R6 semaphore read no drive", {31'd0, l_drive}, 0);
    rd_left(10'd5, 8'hA5, "R6 semaphore write ignored");

    // R8 R10: fresh tie, left wins
    idle(); step();
    setp(1, 1, 10'd20, 8'h11); setp(0, 1, 10'd20, 8'h22);
    #1 chk("R8 right busy on tie", {31'd0, r_busy_o}, 1);
    chk("R8 left not busy on tie", {31'd0, l_busy_o}, 0);
    step(); idle(); step();
    rd_left(10'd20, 8'h11, "R10 winner word stored on tie");

    // R9: right already on the word wins
    idle(); step();
    setp(0, 2, 10'd30, 0); step();
    setp(1, 1, 10'd30, 8'h55); setp(0, 1, 10'd30, 8'h44);
    #1 chk("R9 left busy when right was first", {31'd0, l_busy_o}, 1);
    chk("R9 right not busy", {31'd0, r_busy_o}, 0);
    step();
    setp(1, 1, 10'd30, 8'h56); setp(0, 2, 10'd30, 0);
    #1 chk("R9 winner kept while contention lasts", {31'd0, l_busy_o}, 1);
    step(); idle(); step();
    rd_left(10'd30, 8'h44, "R10 late arrival write dropped");

    // R11: slave mode
    idle(); setp(1, 1, 10'd40, 8'h01); step(); idle();
    ms_sel = 0;
    setp(1, 1, 10'd40, 8'h66); setp(0, 1, 10'd41, 8'h67); l_busy_i = 1;
    #1 chk("R11 busy outputs low in slave", {30'd0, l_busy_o, r_busy_o}, 0);
    step(); idle();
    rd_left(10'd40, 8'h01, "R11 busy input suppresses write");
    rd_left(10'd41, 8'h67, "R11 right write stored");
    setp(1, 1, 10'd50, 8'h0A); setp(0, 1, 10'd50, 8'h0B);
    #1 chk("R11 no internal busy in slave", {30'd0, l_busy_o, r_busy_o}, 0);
    step(); idle();
    rd_left(10'd50, 8'h0A, "R11 left word kept on slave collision");

    // random phase, master mode, eight words
    ms_sel = 1; idle(); step();
    p_la_act = 0; p_ra_act = 0; p_match = 0; p_win = 0; p_la = 0; p_ra = 0;
    for (int i = 0; i < 4; i++)
      cyc(1, 10'(i), 8'(8'h90 + i), 1, 10'(i + 4), 8'(8'hC0 + i));
    for (int i = 0; i < 600; i++)
      cyc(int'($urandom_range(0, 3)), 10'($urandom_range(0, 7)), 8'($urandom),
          int'($urandom_range(0, 3)), 10'($urandom_range(0, 7)), 8'($urandom));
    idle(); step();
    finish_run();
  end
endmodule